// File: doc/BRIEF.md
# VLIW Slot Legality Checker

This block sits at the issue point of a statically scheduled processor that fetches a five-slot instruction word per cycle. Since the compiler has already placed each operation, no hazard detection is done here. Instead the block confirms that every operation sits in a slot wired to its kind of execution unit, evaluates each slot's guarding predicate against the predicate register file, and resolves which predicated branch, if any, is taken.

Every slot carries a valid bit, a 3-bit unit-type code, a predicate register index and a branch target field. One cycle after a word is presented, the block outputs a per-slot issue enable, a taken-branch flag with the chosen slot index and that slot's target, and one error flag. A slot whose predicate is false keeps its place in the word but does not issue. A word with a misplaced operation is dropped entirely. A word in which two or more branch predicates are true takes no branch.

Top module: `vliw_slot_checker`

## Requirements
- R1: Slot number k (1 to 5) is carried on array index k-1. Unit codes are 0 immediate, 1 integer ALU, 2 data memory, 3 branch, 4 DSP ALU, 5 float ALU, 6 divide/square root and 7 reserved. The legal slots are: ALU and immediate in any slot, data memory in slots 4 and 5, branch in slots 2, 3 and 4, DSP ALU in slots 1 and 3, float ALU in slots 1 and 4, and divide/square root in slot 2 only.
- R2: Code 7 is illegal in every slot. A slot whose valid bit is 0 is not checked and never issues.
- R3: If any valid slot holds a type outside its legal slots, the word raises err, clears every issue enable and takes no branch.
- R4: A valid operation issues only when predicate register slot_pidx of pred_regs reads 1. A false predicate clears that slot's issue enable and does not raise err.
- R5: A type-0 slot holds an immediate field. It never issues and never raises err.
- R6: When exactly one valid branch slot has a true predicate in a legal word, br_taken is 1, br_slot is its index (k-1), br_target is its slot_target, and its issue enable is 1.
- R7: When two or more valid branch slots have true predicates, err is 1, br_taken is 0, no branch slot issues, and the other legal slots with true predicates still issue.
- R8: Branches with false predicates are not counted. With no true branch, br_taken is 0 and br_slot and br_target are 0.
- R9: All outputs are registered and reflect the word presented with in_valid one clock earlier. When in_valid was 0, out_valid, issue_en, br_taken, br_slot, br_target and err are all 0.
- R10: Reset is synchronous and active low. While rst_n is 0 at a clock edge, all outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction word is presented this cycle |
| slot_valid | input | 5 | Per-slot occupancy bit |
| slot_type | input | 5x3 | Per-slot unit-type code |
| slot_pidx | input | 5xPIDX_W | Per-slot predicate register index |
| slot_target | input | 5xTGT_W | Per-slot branch target field |
| pred_regs | input | PRED_CNT | Predicate register file read port |
| out_valid | output | 1 | A checked word is on the outputs |
| issue_en | output | 5 | Per-slot issue enable |
| br_taken | output | 1 | A single branch is taken |
| br_slot | output | 3 | Index of the taken branch slot |
| br_target | output | TGT_W | Target of the taken branch |
| err | output | 1 | Misplaced operation or more than one true branch |

## Verification
A wrong slot-rule entry shows up on the next clock edge, either as a spurious err with all issue enables dropped or as a misplaced operation that issues. A wrong predicate lookup appears at once as an issue enable that disagrees with the predicate register value. A branch counter that saturates or miscounts shows up on the same cycle as a taken branch next to a raised err, or as two branch slots issuing together. Vectors place each unit type both inside and outside its legal slots and mix true and false predicates on several branches.

// File: rtl/vliw_chk_pkg.sv
// Package: shared constants, unit-type codes and the slot legality table
// for the VLIW slot legality checker. Assumes a fixed five-slot word.
package vliw_chk_pkg;

    localparam int NSLOT  = 5;
    localparam int TYPE_W = 3;
    localparam int SEL_W  = $clog2(NSLOT);

    typedef enum logic [TYPE_W-1:0] {
        UT_IMM  = 3'd0,
        UT_ALU  = 3'd1,
        UT_DMEM = 3'd2,
        UT_BR   = 3'd3,
        UT_DSP  = 3'd4,
        UT_FALU = 3'd5,
        UT_FDIV = 3'd6,
        UT_RSV  = 3'd7
    } unit_t;

    // Bit k-1 set means slot k may hold the given unit type (R1, R2).
    function automatic logic [NSLOT-1:0] legal_slots(input unit_t t);
        logic [NSLOT-1:0] m;
        case (t)
            UT_IMM:  m = 5'b11111;
            UT_ALU:  m = 5'b11111;
            UT_DMEM: m = 5'b11000;
            UT_BR:   m = 5'b01110;
            UT_DSP:  m = 5'b00101;
            UT_FALU: m = 5'b01001;
            UT_FDIV: m = 5'b00010;
            default: m = 5'b00000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vliw_slot_rule.sv
// Per-slot rule evaluation: placement legality for this slot position,
// predicate lookup and classification. Purely combinational.
// Assumes SLOT_IDX is the zero-based position of the slot in the word.
module vliw_slot_rule
    import vliw_chk_pkg::*;
#(
    parameter int SLOT_IDX = 0,
    parameter int PRED_CNT = 64,
    localparam int PIDX_W  = $clog2(PRED_CNT)
) (
    input  logic                 valid,
    input  logic [TYPE_W-1:0]    utype,
    input  logic [PIDX_W-1:0]    pidx,
    input  logic [PRED_CNT-1:0]  pred_regs,
    output logic                 placed_bad,
    output logic                 branch_live,
    output logic                 is_branch,
    output logic                 wants_issue
);

    unit_t            kind;
    logic             pred_true;
    logic [NSLOT-1:0] allowed;

    // Decode the slot's unit type and read its guarding predicate.
    always_comb begin
        kind      = unit_t'(utype);
        allowed   = legal_slots(kind);
        pred_true = pred_regs[pidx];
    end

    // Classify the slot for the word-level combine (R1, R2, R4, R5).
    always_comb begin
        placed_bad  = valid && !allowed[SLOT_IDX];
        is_branch   = valid && (kind == UT_BR);
        branch_live = is_branch && pred_true;
        wants_issue = valid && (kind != UT_IMM) && pred_true;
    end

endmodule

// File: rtl/vliw_branch_pick.sv
// Branch resolution: counts live (true-predicate) branch slots and picks
// the single one when exactly one is live. Combinational.
// Assumes the caller qualifies branch_live with slot validity.
module vliw_branch_pick
    import vliw_chk_pkg::*;
#(
    parameter int TGT_W = 32
) (
    input  logic [NSLOT-1:0]            branch_live,
    input  logic [NSLOT-1:0][TGT_W-1:0] targets,
    output logic                        one_hit,
    output logic                        multi_hit,
    output logic [SEL_W-1:0]            sel_idx,
    output logic [TGT_W-1:0]            sel_tgt
);

    logic [SEL_W:0] live_cnt;

    // Count live branches and remember the last live one (R6, R7, R8).
    always_comb begin
        live_cnt = '0;
        sel_idx  = '0;
        sel_tgt  = '0;
        for (int i = 0; i < NSLOT; i++) begin
            live_cnt = live_cnt + {{SEL_W{1'b0}}, branch_live[i]};
            if (branch_live[i]) begin
                sel_idx = SEL_W'(i);
                sel_tgt = targets[i];
            end
        end
    end

    // Report whether the word has one live branch or several.
    always_comb begin
        one_hit   = (live_cnt == 1);
        multi_hit = (live_cnt > 1);
    end

endmodule

// File: rtl/vliw_slot_checker.sv
// Top: five-slot VLIW word legality checker. Evaluates per-slot rules,
// resolves the taken branch and registers the result for one cycle.
// Assumes static scheduling (no hazard checks) and a predicate file read
// presented in the same cycle as the word.
module vliw_slot_checker
    import vliw_chk_pkg::*;
#(
    parameter int PRED_CNT = 64,
    parameter int TGT_W    = 32,
    localparam int PIDX_W  = $clog2(PRED_CNT)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [NSLOT-1:0]              slot_valid,
    input  logic [NSLOT-1:0][TYPE_W-1:0]  slot_type,
    input  logic [NSLOT-1:0][PIDX_W-1:0]  slot_pidx,
    input  logic [NSLOT-1:0][TGT_W-1:0]   slot_target,
    input  logic [PRED_CNT-1:0]           pred_regs,
    output logic                          out_valid,
    output logic [NSLOT-1:0]              issue_en,
    output logic                          br_taken,
    output logic [SEL_W-1:0]              br_slot,
    output logic [TGT_W-1:0]              br_target,
    output logic                          err
);

    logic [NSLOT-1:0] placed_bad;
    logic [NSLOT-1:0] branch_live;
    logic [NSLOT-1:0] is_branch;
    logic [NSLOT-1:0] wants_issue;
    logic             one_hit;
    logic             multi_hit;
    logic [SEL_W-1:0] sel_idx;
    logic [TGT_W-1:0] sel_tgt;

    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            vliw_slot_rule #(
                .SLOT_IDX (s),
                .PRED_CNT (PRED_CNT)
            ) u_rule (
                .valid       (slot_valid[s]),
                .utype       (slot_type[s]),
                .pidx        (slot_pidx[s]),
                .pred_regs   (pred_regs),
                .placed_bad  (placed_bad[s]),
                .branch_live (branch_live[s]),
                .is_branch   (is_branch[s]),
                .wants_issue (wants_issue[s])
            );
        end
    endgenerate

    vliw_branch_pick #(
        .TGT_W (TGT_W)
    ) u_pick (
        .branch_live (branch_live),
        .targets     (slot_target),
        .one_hit     (one_hit),
        .multi_hit   (multi_hit),
        .sel_idx     (sel_idx),
        .sel_tgt     (sel_tgt)
    );

    logic             word_bad;
    logic [NSLOT-1:0] issue_d;
    logic             taken_d;
    logic             err_d;

    // Combine slot and branch results into the word verdict (R3, R6, R7).
    always_comb begin
        word_bad = |placed_bad;
        err_d    = word_bad || multi_hit;
        taken_d  = !word_bad && one_hit;
        if (word_bad) begin
            issue_d = '0;
        end else if (multi_hit) begin
            issue_d = wants_issue & ~is_branch;
        end else begin
            issue_d = wants_issue;
        end
    end

    // Output register with synchronous active-low reset (R9, R10).
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid <= 1'b0;
            issue_en  <= '0;
            br_taken  <= 1'b0;
            br_slot   <= '0;
            br_target <= '0;
            err       <= 1'b0;
        end else begin
            out_valid <= 1'b1;
            issue_en  <= issue_d;
            br_taken  <= taken_d;
            br_slot   <= taken_d ? sel_idx : '0;
            br_target <= taken_d ? sel_tgt : '0;
            err       <= err_d;
        end
    end

endmodule

// File: rtl/vliw_slot_checker_sva.sv
// Assertion checker for vliw_slot_checker, attached by bind below.
// Observes ports only; keeps a one-cycle copy of input facts it needs.
module vliw_slot_checker_sva
    import vliw_chk_pkg::*;
#(
    parameter int PRED_CNT = 64,
    parameter int TGT_W    = 32,
    localparam int PIDX_W  = $clog2(PRED_CNT)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [NSLOT-1:0]              slot_valid,
    input  logic [NSLOT-1:0][TYPE_W-1:0]  slot_type,
    input  logic [NSLOT-1:0][PIDX_W-1:0]  slot_pidx,
    input  logic [NSLOT-1:0][TGT_W-1:0]   slot_target,
    input  logic [PRED_CNT-1:0]           pred_regs,
    input  logic                          out_valid,
    input  logic [NSLOT-1:0]              issue_en,
    input  logic                          br_taken,
    input  logic [SEL_W-1:0]              br_slot,
    input  logic [TGT_W-1:0]              br_target,
    input  logic                          err
);

    logic [NSLOT-1:0] br_mask_q;
    logic [NSLOT-1:0] pred_q;
    logic             dmem_s1_q;
    logic             valid_q;

    // Remember last cycle's branch positions, predicates and one bad case.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_mask_q <= '0;
            pred_q    <= '0;
            dmem_s1_q <= 1'b0;
            valid_q   <= 1'b0;
        end else begin
            valid_q   <= in_valid;
            dmem_s1_q <= in_valid && slot_valid[0] && (slot_type[0] == UT_DMEM);
            for (int i = 0; i < NSLOT; i++) begin
                br_mask_q[i] <= slot_valid[i] && (slot_type[i] == UT_BR);
                pred_q[i]    <= pred_regs[slot_pidx[i]];
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (issue_en == '0 && !br_taken && !err && br_target == '0)); // R9

    AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == valid_q); // R9

    AST_TAKEN_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (issue_en[br_slot] && br_mask_q[br_slot])); // R6

    AST_ERR_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !br_taken); // R7

    AST_ONE_BRANCH_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(issue_en & br_mask_q) <= 1); // R7

    AST_BAD_PLACE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_s1_q |-> (err && issue_en == '0)); // R3

    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_pred
            AST_FALSE_PRED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_q && !pred_q[s]) |-> !issue_en[s]); // R4
        end
    endgenerate

endmodule

bind vliw_slot_checker vliw_slot_checker_sva #(
    .PRED_CNT (PRED_CNT),
    .TGT_W    (TGT_W)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .slot_valid  (slot_valid),
    .slot_type   (slot_type),
    .slot_pidx   (slot_pidx),
    .slot_target (slot_target),
    .pred_regs   (pred_regs),
    .out_valid   (out_valid),
    .issue_en    (issue_en),
    .br_taken    (br_taken),
    .br_slot     (br_slot),
    .br_target   (br_target),
    .err         (err)
);

// File: tb/vliw_slot_checker_test.sv
// Self-checking bench: vector table walked by one loop, then directed
// tests for reset, idle cycles and predicate file changes.
module vliw_slot_checker_test;
    import vliw_chk_pkg::*;

    localparam int PRED_CNT = 64;
    localparam int TGT_W    = 32;
    localparam int PIDX_W   = $clog2(PRED_CNT);

    logic                          clk = 1'b0;
    logic                          rst_n;
    logic                          in_valid;
    logic [NSLOT-1:0]              slot_valid;
    logic [NSLOT-1:0][TYPE_W-1:0]  slot_type;
    logic [NSLOT-1:0][PIDX_W-1:0]  slot_pidx;
    logic [NSLOT-1:0][TGT_W-1:0]   slot_target;
    logic [PRED_CNT-1:0]           pred_regs;
    logic                          out_valid;
    logic [NSLOT-1:0]              issue_en;
    logic                          br_taken;
    logic [SEL_W-1:0]              br_slot;
    logic [TGT_W-1:0]              br_target;
    logic                          err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vliw_slot_checker #(.PRED_CNT(PRED_CNT), .TGT_W(TGT_W)) uut (.*);

    // ty is {slot5..slot1}; p bit set selects a true predicate (register 1),
    // clear selects a false one (register 2).
    typedef struct packed {
        logic [14:0] ty;
        logic [4:0]  v;
        logic [4:0]  p;
        logic [4:0]  iss;
        logic        er;
        logic        br;
        logic [2:0]  bs;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{{3'd1,3'd1,3'd1,3'd1,3'd1}, 5'b11111, 5'b11111, 5'b11111, 1'b0, 1'b0, 3'd0}, // R1 all ALU
        '{{3'd2,3'd5,3'd3,3'd6,3'd4}, 5'b11111, 5'b11111, 5'b11111, 1'b0, 1'b1, 3'd2}, // R1 R6 every unit legal
        '{{3'd1,3'd1,3'd1,3'd1,3'd2}, 5'b11111, 5'b11111, 5'b00000, 1'b1, 1'b0, 3'd0}, // R3 dmem slot1
        '{{3'd3,3'd1,3'd1,3'd1,3'd1}, 5'b11111, 5'b11111, 5'b00000, 1'b1, 1'b0, 3'd0}, // R3 branch slot5
        '{{3'd1,3'd1,3'd6,3'd1,3'd1}, 5'b11111, 5'b11111, 5'b00000, 1'b1, 1'b0, 3'd0}, // R3 divide slot3
        '{{3'd1,3'd3,3'd1,3'd3,3'd1}, 5'b11111, 5'b11111, 5'b10101, 1'b1, 1'b0, 3'd0}, // R7 two true branches
        '{{3'd1,3'd3,3'd1,3'd3,3'd1}, 5'b11111, 5'b11101, 5'b11101, 1'b0, 1'b1, 3'd3}, // R8 one branch false
        '{{3'd1,3'd1,3'd1,3'd1,3'd1}, 5'b11111, 5'b01110, 5'b01110, 1'b0, 1'b0, 3'd0}, // R4 false predicates
        '{{3'd1,3'd1,3'd1,3'd0,3'd0}, 5'b11111, 5'b11111, 5'b11100, 1'b0, 1'b0, 3'd0}, // R5 immediates
        '{{3'd1,3'd1,3'd7,3'd1,3'd1}, 5'b11111, 5'b11111, 5'b00000, 1'b1, 1'b0, 3'd0}, // R2 reserved code
        '{{3'd1,3'd1,3'd1,3'd1,3'd2}, 5'b11110, 5'b11111, 5'b11110, 1'b0, 1'b0, 3'd0}, // R2 invalid slot unchecked
        '{{3'd1,3'd1,3'd1,3'd4,3'd1}, 5'b11111, 5'b11111, 5'b00000, 1'b1, 1'b0, 3'd0}, // R3 DSP slot2
        '{{3'd5,3'd1,3'd1,3'd1,3'd1}, 5'b11111, 5'b11111, 5'b00000, 1'b1, 1'b0, 3'd0}, // R3 float slot5
        '{{3'd1,3'd1,3'd3,3'd1,3'd1}, 5'b11111, 5'b11011, 5'b11011, 1'b0, 1'b0, 3'd0}, // R8 lone false branch
        '{{3'd1,3'd3,3'd3,3'd3,3'd1}, 5'b11111, 5'b11111, 5'b10001, 1'b1, 1'b0, 3'd0}  // R7 three true branches
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_vec(input vec_t vc);
        slot_type  = vc.ty;
        slot_valid = vc.v;
        for (int i = 0; i < NSLOT; i++) begin
            slot_pidx[i]   = vc.p[i] ? PIDX_W'(1) : PIDX_W'(2);
            slot_target[i] = 32'h1000 + i;
        end
    endtask

    task automatic check_out(input string tag, input vec_t vc);
        chk({tag, " out_valid"}, 64'(out_valid), 64'(1'b1));
        chk({tag, " issue_en"},  64'(issue_en),  64'(vc.iss));
        chk({tag, " err"},       64'(err),       64'(vc.er));
        chk({tag, " br_taken"},  64'(br_taken),  64'(vc.br));
        chk({tag, " br_slot"},   64'(br_slot),   64'(vc.bs));
        chk({tag, " br_target"}, 64'(br_target), vc.br ? 64'(32'h1000 + vc.bs) : 64'd0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        in_valid  = 1'b1;
        pred_regs = {32{2'b10}};
        drive_vec(VECS[0]);
        repeat (3) @(negedge clk);
        // R10: outputs held at zero while reset is low, even with a word.
        chk("R10 out_valid in reset", 64'(out_valid), 64'd0);
        chk("R10 issue_en in reset",  64'(issue_en),  64'd0);
        chk("R10 err in reset",       64'(err),       64'd0);
        rst_n = 1'b1;

        // Table walk, back to back words.
        for (int k = 0; k < NV; k++) begin
            drive_vec(VECS[k]);
            @(negedge clk);
            check_out($sformatf("vec%0d", k), VECS[k]);
        end

        // R9: an idle cycle clears every output.
        in_valid = 1'b0;
        drive_vec(VECS[1]);
        @(negedge clk);
        chk("R9 idle out_valid", 64'(out_valid), 64'd0);
        chk("R9 idle issue_en",  64'(issue_en),  64'd0);
        chk("R9 idle br_taken",  64'(br_taken),  64'd0);
        chk("R9 idle br_target", 64'(br_target), 64'd0);

        // R4: predicate file cleared, legal word issues nothing and no err.
        in_valid  = 1'b1;
        pred_regs = '0;
        drive_vec(VECS[1]);
        @(negedge clk);
        chk("R4 all false issue_en", 64'(issue_en), 64'd0);
        chk("R4 all false err",      64'(err),      64'd0);
        chk("R8 all false br_taken", 64'(br_taken), 64'd0);

        // R6: high predicate index, branch in slot 4 with distinct target.
        pred_regs     = '0;
        pred_regs[63] = 1'b1;
        slot_type  = {3'd1, 3'd3, 3'd1, 3'd1, 3'd1};
        slot_valid = 5'b11111;
        for (int i = 0; i < NSLOT; i++) slot_pidx[i] = PIDX_W'(63);
        slot_target[3] = 32'hCAFE_0040;
        @(negedge clk);
        chk("R6 br_taken",  64'(br_taken),  64'd1);
        chk("R6 br_slot",   64'(br_slot),   64'd3);
        chk("R6 br_target", 64'(br_target), 64'hCAFE_0040);
        chk("R6 issue_en",  64'(issue_en),  64'h1F);

        // R10: synchronous reset mid-stream clears a live result.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid reset out_valid", 64'(out_valid), 64'd0);
        chk("R10 mid reset br_taken",  64'(br_taken),  64'd0);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule